// File: doc/BRIEF.md
# Transmit Attempt Sequencer with FCS Selection

This block runs the transmission attempts of one outgoing frame. A frame request comes in on a valid/ready handshake. When the block accepts it, the block latches the mode bits and the descriptor flags that came with the request. It then issues one strobe per attempt. After each collision it waits for an external backoff timer before it tries again. When an attempt succeeds it reports done. When the attempt budget is used up it reports a retry error.

The block makes two more decisions that hold for the whole frame. The first is whether the transmitter appends a frame check sequence. Three inputs override the global "suppress FCS" mode bit: the per-frame pair of add-FCS plus end-of-packet, and the auto-pad mode. The second is whether the first bytes of the frame must stay protected in the transmit FIFO so that a retransmission can read them again. A test mode forces a collision on every attempt, but only while internal loopback is selected. The backoff timer, the CRC arithmetic and the medium interface live outside this block.

Top module: `tx_attempt_ctrl`

## Requirements
- R1: After reset, `frm_ready` is 1 and `att_start`, `done`, `retry_err`, `fcs_en` and `fifo_hold` are all 0.
- R2: A request is accepted on a clock edge where `frm_valid` and `frm_ready` are both 1. In the next cycle `att_start` is high for exactly one cycle and `frm_ready` is low.
- R3: `mac_ok` during an attempt, with no collision in effect, produces a one-cycle `done` pulse. In the same cycle `frm_ready` returns to 1 and `fifo_hold` returns to 0.
- R4: With `mode_no_retry` = 0, a frame gets up to 16 attempts (parameter `MAX_ATTEMPTS`). If all 16 attempts collide, the block gives a one-cycle `retry_err` pulse after exactly 16 `att_start` strobes.
- R5: With `mode_no_retry` = 1, the block makes exactly one attempt. A collision on that attempt ends the frame with `retry_err`.
- R6: While a frame is in progress, `fifo_hold` is 1 if `mode_no_retry` was 0 at acceptance, and 0 if it was 1.
- R7: After a collision that leaves attempts remaining, the block issues no new `att_start` until `backoff_done` is seen. The next strobe follows the cycle in which `backoff_done` is sampled.
- R8: If `mode_force_coll` and `mode_loopback` are both 1 at acceptance, every attempt counts as a collision, even when `mac_ok` is asserted, so the frame ends in `retry_err` after the full budget.
- R9: `mode_force_coll` with `mode_loopback` at 0 has no effect: `mac_ok` still completes the frame with `done`.
- R10: With `mode_auto_pad` = 0 and the per-frame pair not both set, `fcs_en` during the frame equals the inverse of `mode_no_fcs`.
- R11: If `dsc_add_fcs` and `dsc_eop` are both 1, `fcs_en` is 1 whatever `mode_no_fcs` is. Either flag alone does not override `mode_no_fcs`.
- R12: If `mode_auto_pad` is 1, `fcs_en` is 1 whatever `mode_no_fcs` is.
- R13: The attempt count restarts at every accepted request, so each new frame gets the full budget whatever the previous frame used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Frame request valid |
| frm_ready | output | 1 | Block idle, ready to accept a frame |
| dsc_add_fcs | input | 1 | Per-frame add-FCS flag |
| dsc_eop | input | 1 | Per-frame end-of-packet flag |
| mode_no_retry | input | 1 | Single attempt only |
| mode_force_coll | input | 1 | Force a collision on every attempt (loopback only) |
| mode_loopback | input | 1 | Internal loopback selected |
| mode_no_fcs | input | 1 | Suppress FCS by default |
| mode_auto_pad | input | 1 | Auto-pad on; forces FCS |
| mac_coll | input | 1 | Collision on the current attempt |
| mac_ok | input | 1 | Current attempt finished cleanly |
| backoff_done | input | 1 | Backoff interval elapsed |
| att_start | output | 1 | One-cycle strobe: start an attempt |
| fcs_en | output | 1 | Append FCS for the active frame |
| fifo_hold | output | 1 | Protect frame head in the FIFO |
| done | output | 1 | One-cycle frame success pulse |
| retry_err | output | 1 | One-cycle retry-exhausted pulse |

## Verification
The hardest case to reach is the sixteenth collision. It only follows fifteen full cycles of collision, backoff and strobe, and a miscount at the limit shows up in just one cycle. The driver scripts a per-frame number of collisions and answers every strobe at the ports. It counts strobes up to the limit and one short of it. It also runs a forced-loopback frame in which `mac_ok` is asserted on every attempt, which checks that the forced collision takes precedence over a clean finish.

// File: rtl/tx_attempt_pkg.sv
package tx_attempt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_START   = 2'd1,
        ST_ATTEMPT = 2'd2,
        ST_BACKOFF = 2'd3
    } att_state_e;

    // Per-frame settings captured when a request is accepted
    typedef struct packed {
        logic single_shot;  // no retransmission allowed
        logic force_coll;   // forced collision, already qualified by loopback
        logic fcs;          // append FCS
    } frame_cfg_t;

    // FCS precedence: auto-pad, then the per-frame pair, then the global suppress bit
    function automatic logic fcs_decide(input logic auto_pad,
                                        input logic add_fcs,
                                        input logic eop,
                                        input logic no_fcs);
        if (auto_pad)
            return 1'b1;
        else if (add_fcs && eop)
            return 1'b1;
        else
            return !no_fcs;
    endfunction

endpackage

// File: rtl/tx_fcs_select.sv
module tx_fcs_select
    import tx_attempt_pkg::*;
(
    input  logic dsc_add_fcs,
    input  logic dsc_eop,
    input  logic mode_no_fcs,
    input  logic mode_auto_pad,
    output logic fcs_want
);
    always_comb begin
        fcs_want = fcs_decide(mode_auto_pad, dsc_add_fcs, dsc_eop, mode_no_fcs);
    end
endmodule

// File: rtl/tx_attempt_seq.sv
module tx_attempt_seq
    import tx_attempt_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic accept_req,
    input  frame_cfg_t cfg_in,
    input  logic mac_coll,
    input  logic mac_ok,
    input  logic backoff_done,
    output logic idle,
    output logic att_start,
    output logic active_fcs,
    output logic active_hold,
    output logic done,
    output logic retry_err
);
    localparam int CW = $clog2(MAX_ATTEMPTS + 1);

    att_state_e      state;
    frame_cfg_t      cfg;
    logic [CW-1:0]   att_cnt;
    logic [CW-1:0]   att_limit;
    logic            coll_now;
    logic            done_q;
    logic            err_q;

    always_comb begin
        att_limit = cfg.single_shot ? CW'(1) : CW'(MAX_ATTEMPTS);
        coll_now  = cfg.force_coll || mac_coll;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cfg     <= '0;
            att_cnt <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept_req) begin
                        cfg     <= cfg_in;
                        att_cnt <= CW'(1);
                        state   <= ST_START;
                    end
                end
                ST_START: state <= ST_ATTEMPT;
                ST_ATTEMPT: begin
                    if (coll_now) begin
                        if (att_cnt >= att_limit) begin
                            err_q <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_BACKOFF;
                        end
                    end else if (mac_ok) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                ST_BACKOFF: begin
                    if (backoff_done) begin
                        att_cnt <= att_cnt + CW'(1);
                        state   <= ST_START;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        idle        = (state == ST_IDLE);
        att_start   = (state == ST_START);
        active_fcs  = !idle && cfg.fcs;
        active_hold = !idle && !cfg.single_shot;
        done        = done_q;
        retry_err   = err_q;
    end
endmodule

// File: rtl/tx_attempt_ctrl.sv
module tx_attempt_ctrl
    import tx_attempt_pkg::*;
#(
    parameter int MAX_ATTEMPTS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic frm_valid,
    output logic frm_ready,
    input  logic dsc_add_fcs,
    input  logic dsc_eop,
    input  logic mode_no_retry,
    input  logic mode_force_coll,
    input  logic mode_loopback,
    input  logic mode_no_fcs,
    input  logic mode_auto_pad,
    input  logic mac_coll,
    input  logic mac_ok,
    input  logic backoff_done,
    output logic att_start,
    output logic fcs_en,
    output logic fifo_hold,
    output logic done,
    output logic retry_err
);
    logic       fcs_want;
    logic       idle;
    frame_cfg_t cfg_in;

    tx_fcs_select u_fcs (
        .dsc_add_fcs   (dsc_add_fcs),
        .dsc_eop       (dsc_eop),
        .mode_no_fcs   (mode_no_fcs),
        .mode_auto_pad (mode_auto_pad),
        .fcs_want      (fcs_want)
    );

    always_comb begin
        cfg_in.single_shot = mode_no_retry;
        cfg_in.force_coll  = mode_force_coll && mode_loopback;
        cfg_in.fcs         = fcs_want;
    end

    tx_attempt_seq #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .accept_req   (frm_valid && idle),
        .cfg_in       (cfg_in),
        .mac_coll     (mac_coll),
        .mac_ok       (mac_ok),
        .backoff_done (backoff_done),
        .idle         (idle),
        .att_start    (att_start),
        .active_fcs   (fcs_en),
        .active_hold  (fifo_hold),
        .done         (done),
        .retry_err    (retry_err)
    );

    assign frm_ready = idle;
endmodule

// File: rtl/tx_attempt_ctrl_chk.sv
module tx_attempt_ctrl_chk #(
    parameter int MAX_ATTEMPTS = 16
) (
    input logic clk,
    input logic rst,
    input logic frm_valid,
    input logic frm_ready,
    input logic mode_no_retry,
    input logic att_start,
    input logic fcs_en,
    input logic fifo_hold,
    input logic done,
    input logic retry_err
);
    localparam int CW = $clog2(MAX_ATTEMPTS + 2);
    logic [CW-1:0] strobes;

    always_ff @(posedge clk) begin
        if (rst)
            strobes <= '0;
        else if (frm_valid && frm_ready)
            strobes <= '0;
        else if (att_start)
            strobes <= strobes + CW'(1);
    end

    // R1: reset leaves the block idle with all strobes quiet
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (frm_ready && !att_start && !done && !retry_err && !fifo_hold));

    // R2: an accepted request is followed by a single-cycle strobe
    assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_ready) |=> (att_start && !frm_ready));
    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        att_start |=> !att_start);

    // R3: done and retry error are exclusive and leave the block idle
    assert_end_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        !(done && retry_err));
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (frm_ready && !fifo_hold));

    // R4: never more strobes than the budget in one frame
    assert_attempt_cap_R4: assert property (@(posedge clk) disable iff (rst)
        att_start |-> (strobes < CW'(MAX_ATTEMPTS)));

    // R6: FIFO protection only while a frame is in progress
    assert_hold_busy_R6: assert property (@(posedge clk) disable iff (rst)
        fifo_hold |-> !frm_ready);

    // R10: FCS decision is stable through a frame
    assert_fcs_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!frm_ready && $past(!frm_ready) && !$past(rst)) |-> $stable(fcs_en));
endmodule

bind tx_attempt_ctrl tx_attempt_ctrl_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .frm_valid     (frm_valid),
    .frm_ready     (frm_ready),
    .mode_no_retry (mode_no_retry),
    .att_start     (att_start),
    .fcs_en        (fcs_en),
    .fifo_hold     (fifo_hold),
    .done          (done),
    .retry_err     (retry_err)
);

// File: tb/tx_attempt_ctrl_bench.sv
module tx_attempt_ctrl_bench;
    localparam int MAXA = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frm_valid = 0, dsc_add_fcs = 0, dsc_eop = 0;
    logic mode_no_retry = 0, mode_force_coll = 0, mode_loopback = 0;
    logic mode_no_fcs = 0, mode_auto_pad = 0;
    logic mac_coll = 0, mac_ok = 0, backoff_done = 0;
    logic frm_ready, att_start, fcs_en, fifo_hold, done, retry_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        bit    is_err;
        int    attempts;
        bit    fcs;
        bit    hold;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    tx_attempt_ctrl #(.MAX_ATTEMPTS(MAXA)) u_tx_attempt_ctrl (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .dsc_add_fcs(dsc_add_fcs), .dsc_eop(dsc_eop),
        .mode_no_retry(mode_no_retry), .mode_force_coll(mode_force_coll),
        .mode_loopback(mode_loopback), .mode_no_fcs(mode_no_fcs),
        .mode_auto_pad(mode_auto_pad), .mac_coll(mac_coll), .mac_ok(mac_ok),
        .backoff_done(backoff_done), .att_start(att_start), .fcs_en(fcs_en),
        .fifo_hold(fifo_hold), .done(done), .retry_err(retry_err)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Monitor: count strobes, record per-frame flags, compare on frame end
    int seen_att = 0;
    bit seen_fcs = 0, seen_hold = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (att_start) begin
                seen_att++;
                seen_fcs  = fcs_en;
                seen_hold = fifo_hold;
            end
            if (done || retry_err) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check("R3 unexpected frame end", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({e.tag, " outcome(1=retry_err)"}, int'(retry_err), int'(e.is_err));
                    check({e.tag, " attempts"}, seen_att, e.attempts);
                    check({e.tag, " R10 fcs_en"}, int'(seen_fcs), int'(e.fcs));
                    check({e.tag, " R6 fifo_hold"}, int'(seen_hold), int'(e.hold));
                end
                seen_att = 0;
            end
        end
    end

    // Driver: apply one frame, answer every strobe, push the expectation
    task automatic run_frame(input string tag, input bit nr, input bit fc, input bit lb,
                             input bit nf, input bit ap, input bit add, input bit eop,
                             input int ncoll, input bit ok_when_forced);
        exp_t e;
        bit forced = fc && lb;
        int lim = nr ? 1 : MAXA;
        e.tag  = tag;
        e.fcs  = ap || (add && eop) || !nf;
        e.hold = !nr;
        if (forced || ncoll >= lim) begin
            e.is_err = 1; e.attempts = lim;
        end else begin
            e.is_err = 0; e.attempts = ncoll + 1;
        end
        exp_q.push_back(e);
        while (!frm_ready) @(negedge clk);
        mode_no_retry = nr; mode_force_coll = fc; mode_loopback = lb;
        mode_no_fcs = nf; mode_auto_pad = ap; dsc_add_fcs = add; dsc_eop = eop;
        frm_valid = 1;
        @(negedge clk);
        frm_valid = 0;
        check({tag, " R2 strobe after accept"}, int'(att_start), 1);
        for (int a = 1; a <= e.attempts; a++) begin
            while (!att_start) @(negedge clk);
            @(negedge clk);
            if (forced) begin
                mac_ok = ok_when_forced;
            end else if (a <= ncoll) begin
                mac_coll = 1;
            end else begin
                mac_ok = 1;
            end
            @(negedge clk);
            mac_ok = 0; mac_coll = 0;
            if (a < e.attempts) begin
                for (int w = 0; w < 3; w++) begin
                    if (a == 1 && w == 0)
                        check({tag, " R7 no strobe before backoff_done"}, int'(att_start), 0);
                    else if (att_start) check({tag, " R7 no strobe before backoff_done"}, 1, 0);
                    @(negedge clk);
                end
                backoff_done = 1;
                @(negedge clk);
                backoff_done = 0;
            end else begin
                check({tag, " R3 ready after end"}, int'(frm_ready), 1);
                check({tag, " R3 hold released"}, int'(fifo_hold), 0);
            end
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 frm_ready", int'(frm_ready), 1);
        check("R1 att_start", int'(att_start), 0);
        check("R1 done/retry_err", int'(done || retry_err), 0);
        check("R1 fcs_en/fifo_hold", int'(fcs_en || fifo_hold), 0);

        //        tag                       nr fc lb nf ap ad eo ncoll okf
        run_frame("R3 clean frame",          0, 0, 0, 0, 0, 0, 0, 0,  0);
        run_frame("R7 three collisions",     0, 0, 0, 0, 0, 0, 0, 3,  0);
        run_frame("R4 sixteen collisions",   0, 0, 0, 0, 0, 0, 0, 16, 0);
        run_frame("R4 fifteen then ok",      0, 0, 0, 0, 0, 0, 0, 15, 0);
        run_frame("R13 fresh budget",        0, 0, 0, 0, 0, 0, 0, 2,  0);
        run_frame("R5 single shot collide",  1, 0, 0, 0, 0, 0, 0, 1,  0);
        run_frame("R5 single shot ok",       1, 0, 0, 0, 0, 0, 0, 0,  0);
        run_frame("R8 forced loopback",      0, 1, 1, 0, 0, 0, 0, 0,  1);
        run_frame("R8 forced single shot",   1, 1, 1, 0, 0, 0, 0, 0,  1);
        run_frame("R9 force w/o loopback",   0, 1, 0, 0, 0, 0, 0, 0,  0);
        run_frame("R10 fcs suppressed",      0, 0, 0, 1, 0, 0, 0, 0,  0);
        run_frame("R11 add+eop override",    0, 0, 0, 1, 0, 1, 1, 0,  0);
        run_frame("R11 add only",            0, 0, 0, 1, 0, 1, 0, 0,  0);
        run_frame("R11 eop only",            0, 0, 0, 1, 0, 0, 1, 1,  0);
        run_frame("R12 auto pad override",   0, 0, 0, 1, 1, 0, 0, 1,  0);

        repeat (4) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule